// File: doc/BRIEF.md
# Command Method Dispatcher

This block takes a stream of method calls. Each call carries a subchannel index, a method number and a 32-bit argument. A method number is a word index, so its byte offset is the number times four. Calls numbered below a fixed boundary are executed locally by a puller that owns a 256-word register array. Calls at or above the boundary are sent on to whichever engine the call's subchannel is currently bound to.

The puller stores every local call's argument in its register array, at the index given by the method number. A few local methods then act further. One rebinds the call's subchannel to a new engine id. Three hand a request to an external semaphore unit. The remaining recognised methods only update the array. Any other local method number raises a one-cycle "unsupported" pulse. While the semaphore unit reports busy or an acquire pending, the input holds ready low and the stream stalls.

Top module: `cmd_method_dispatch`

## Requirements
- R1: After reset, every output pulse is low, `in_ready` is high, the binding table holds engine 0 for all subchannels and every register word reads 0.
- R2: An accepted call with method number at or above 0x40 produces, in the next cycle, a one-cycle `eng_valid` carrying the engine id bound to its subchannel, its method number and its argument. It writes no register.
- R3: An accepted call with method number below 0x40 writes its argument into register word `method`. `reg_rd_data` shows the new value for `reg_rd_idx == method` from the next cycle on. It never raises `eng_valid`.
- R4: Local method 0x0 sets the binding of the call's subchannel to `in_arg[7:0]`. Later forwarded calls on that subchannel carry this id.
- R5: Local methods 0x2, 0x4, 0x5, 0x6 and 0x14 update only their register word. No `eng_valid`, `sem_valid` or `unsup_valid` follows them.
- R6: Local methods 0x7, 0x1A and 0x1B produce, in the next cycle, a one-cycle `sem_valid`. `sem_kind` is 1, 2 or 3 respectively, `sem_arg` is the call's argument, `sem_addr` is {word 0x4, word 0x5} and `sem_seq` is word 0x6.
- R7: Every other local method number, including 0x8, 0x9, 0xA, 0xB and 0x20, produces in the next cycle a one-cycle `unsup_valid` with `unsup_method` equal to the method number. It has no other action.
- R8: `in_ready` is low whenever `sem_busy` or `sem_acq_pending` is high. A call offered then is not taken and has no effect.
- R9: `refcnt` always equals register word 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Method call offered |
| in_ready | output | 1 | Method call can be taken |
| in_subch | input | 3 | Subchannel of the call |
| in_method | input | 12 | Method number (word index) |
| in_arg | input | 32 | Call argument |
| eng_valid | output | 1 | Forwarded call pulse |
| eng_id | output | 8 | Engine bound to the call's subchannel |
| eng_method | output | 12 | Forwarded method number |
| eng_arg | output | 32 | Forwarded argument |
| sem_valid | output | 1 | Semaphore request pulse |
| sem_kind | output | 2 | 1 trigger, 2 acquire, 3 release |
| sem_arg | output | 32 | Argument of the semaphore call |
| sem_addr | output | 64 | Semaphore address from words 0x4 (high) and 0x5 (low) |
| sem_seq | output | 32 | Sequence word 0x6 |
| sem_busy | input | 1 | Semaphore unit busy |
| sem_acq_pending | input | 1 | Semaphore acquire still pending |
| unsup_valid | output | 1 | Unsupported local method pulse |
| unsup_method | output | 12 | Number of the unsupported method |
| refcnt | output | 32 | Reference count word 0x14 |
| reg_rd_idx | input | 8 | Register array read index |
| reg_rd_data | output | 32 | Register array word at `reg_rd_idx` |

## Verification
The bench builds the block with its default parameters: eight subchannels, 12-bit method numbers, a 256-word array and the boundary at 0x40. That method width reaches forwarded numbers up to 0xFFF, and three subchannel bits let every binding entry be rebound and then used. Random calls are mixed with stall inputs, so the bench sees calls held during stalls, binds followed at once by forwards on the same subchannel, and semaphore requests made right after the address and sequence words change.

// File: rtl/cmd_method_dispatch.sv
module cmd_method_dispatch #(
  parameter int SUBCH       = 8,
  parameter int ENG_W       = 8,
  parameter int METH_W      = 12,
  parameter int NREGS       = 256,
  parameter int LOCAL_LIMIT = 'h40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [$clog2(SUBCH)-1:0]   in_subch,
  input  logic [METH_W-1:0]          in_method,
  input  logic [31:0]                in_arg,
  output logic                       eng_valid,
  output logic [ENG_W-1:0]           eng_id,
  output logic [METH_W-1:0]          eng_method,
  output logic [31:0]                eng_arg,
  output logic                       sem_valid,
  output logic [1:0]                 sem_kind,
  output logic [31:0]                sem_arg,
  output logic [63:0]                sem_addr,
  output logic [31:0]                sem_seq,
  input  logic                       sem_busy,
  input  logic                       sem_acq_pending,
  output logic                       unsup_valid,
  output logic [METH_W-1:0]          unsup_method,
  output logic [31:0]                refcnt,
  input  logic [$clog2(NREGS)-1:0]   reg_rd_idx,
  output logic [31:0]                reg_rd_data
);
  localparam int SC_W  = $clog2(SUBCH);
  localparam int IDX_W = $clog2(NREGS);

  localparam logic [IDX_W-1:0] M_BIND    = IDX_W'('h00);
  localparam logic [IDX_W-1:0] M_NOP     = IDX_W'('h02);
  localparam logic [IDX_W-1:0] M_ADDR_HI = IDX_W'('h04);
  localparam logic [IDX_W-1:0] M_ADDR_LO = IDX_W'('h05);
  localparam logic [IDX_W-1:0] M_SEQ     = IDX_W'('h06);
  localparam logic [IDX_W-1:0] M_TRIG    = IDX_W'('h07);
  localparam logic [IDX_W-1:0] M_REFCNT  = IDX_W'('h14);
  localparam logic [IDX_W-1:0] M_ACQ     = IDX_W'('h1A);
  localparam logic [IDX_W-1:0] M_REL     = IDX_W'('h1B);

  logic [31:0]      regs [NREGS];
  logic [ENG_W-1:0] bind_tbl [SUBCH];

  logic             accept, is_local;
  logic [IDX_W-1:0] idx;

  assign in_ready = !(sem_busy || sem_acq_pending);
  assign accept   = in_valid && in_ready;
  assign is_local = in_method < METH_W'(LOCAL_LIMIT);
  assign idx      = in_method[IDX_W-1:0];

  assign sem_addr    = {regs[M_ADDR_HI], regs[M_ADDR_LO]};
  assign sem_seq     = regs[M_SEQ];
  assign refcnt      = regs[M_REFCNT];
  assign reg_rd_data = regs[reg_rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      for (int s = 0; s < SUBCH; s++) bind_tbl[s] <= '0;
    end else if (accept && is_local) begin
      regs[idx] <= in_arg;
      if (idx == M_BIND) bind_tbl[in_subch] <= in_arg[ENG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_valid    <= 1'b0;
      eng_id       <= '0;
      eng_method   <= '0;
      eng_arg      <= '0;
      sem_valid    <= 1'b0;
      sem_kind     <= 2'd0;
      sem_arg      <= '0;
      unsup_valid  <= 1'b0;
      unsup_method <= '0;
    end else begin
      eng_valid   <= 1'b0;
      sem_valid   <= 1'b0;
      unsup_valid <= 1'b0;
      if (accept && !is_local) begin
        eng_valid  <= 1'b1;
        eng_id     <= bind_tbl[in_subch];
        eng_method <= in_method;
        eng_arg    <= in_arg;
      end else if (accept) begin
        case (idx)
          M_BIND, M_NOP, M_ADDR_HI, M_ADDR_LO, M_SEQ, M_REFCNT: ;
          M_TRIG: begin sem_valid <= 1'b1; sem_kind <= 2'd1; sem_arg <= in_arg; end
          M_ACQ:  begin sem_valid <= 1'b1; sem_kind <= 2'd2; sem_arg <= in_arg; end
          M_REL:  begin sem_valid <= 1'b1; sem_kind <= 2'd3; sem_arg <= in_arg; end
          default: begin unsup_valid <= 1'b1; unsup_method <= in_method; end
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_method_dispatch_chk.sv
module cmd_method_dispatch_chk #(
  parameter int METH_W      = 12,
  parameter int LOCAL_LIMIT = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [METH_W-1:0] in_method,
  input logic [31:0]       in_arg,
  input logic              eng_valid,
  input logic [METH_W-1:0] eng_method,
  input logic [31:0]       eng_arg,
  input logic              sem_valid,
  input logic              sem_busy,
  input logic              sem_acq_pending,
  input logic              unsup_valid,
  input logic [METH_W-1:0] unsup_method,
  input logic [31:0]       refcnt
);
  logic acc, loc;
  assign acc = in_valid && in_ready;
  assign loc = in_method < METH_W'(LOCAL_LIMIT);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_busy || sem_acq_pending) |-> !in_ready);

  assert_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !loc) |=> (eng_valid && eng_method == $past(in_method) && eng_arg == $past(in_arg)));

  assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && loc) |=> !eng_valid);

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_method == METH_W'('h2) || in_method == METH_W'('h14)))
      |=> !(eng_valid || sem_valid || unsup_valid));

  assert_sem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_method == METH_W'('h7) || in_method == METH_W'('h1A) || in_method == METH_W'('h1B)))
      |=> sem_valid);

  assert_unsup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_method == METH_W'('h8) || in_method == METH_W'('h20)))
      |=> (unsup_valid && unsup_method == $past(in_method)));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !(eng_valid || sem_valid || unsup_valid));

  assert_refcnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_method == METH_W'('h14)) |=> refcnt == $past(in_arg));

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_valid, sem_valid, unsup_valid}));
endmodule

bind cmd_method_dispatch cmd_method_dispatch_chk #(.METH_W(METH_W), .LOCAL_LIMIT(LOCAL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_method(in_method), .in_arg(in_arg), .eng_valid(eng_valid),
  .eng_method(eng_method), .eng_arg(eng_arg), .sem_valid(sem_valid),
  .sem_busy(sem_busy), .sem_acq_pending(sem_acq_pending),
  .unsup_valid(unsup_valid), .unsup_method(unsup_method), .refcnt(refcnt)
);

// File: tb/tb_cmd_method_dispatch.sv
`timescale 1ns/1ps
module tb_cmd_method_dispatch;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [2:0]  in_subch = 0;
  logic [11:0] in_method = 0;
  logic [31:0] in_arg = 0;
  logic        eng_valid, sem_valid, unsup_valid;
  logic [7:0]  eng_id;
  logic [11:0] eng_method, unsup_method;
  logic [31:0] eng_arg, sem_arg, sem_seq, refcnt, reg_rd_data;
  logic [1:0]  sem_kind;
  logic [63:0] sem_addr;
  logic        sem_busy = 0, sem_acq_pending = 0;
  logic [7:0]  reg_rd_idx = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] mregs [256];
  logic [7:0]  mbind [8];
  bit e_eng, e_sem, e_uns;
  logic [7:0]  e_id;
  logic [11:0] e_m;
  logic [31:0] e_a;
  logic [1:0]  e_kind;

  always #2.5 clk = ~clk;

  cmd_method_dispatch dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(eng_valid === e_eng, "R2 eng_valid", 64'(eng_valid), 64'(e_eng));
    if (e_eng) begin
      chk(eng_id === e_id, "R4 eng_id", 64'(eng_id), 64'(e_id));
      chk(eng_method === e_m, "R2 eng_method", 64'(eng_method), 64'(e_m));
      chk(eng_arg === e_a, "R2 eng_arg", 64'(eng_arg), 64'(e_a));
    end
    chk(sem_valid === e_sem, "R6 sem_valid", 64'(sem_valid), 64'(e_sem));
    if (e_sem) begin
      chk(sem_kind === e_kind, "R6 sem_kind", 64'(sem_kind), 64'(e_kind));
      chk(sem_arg === e_a, "R6 sem_arg", 64'(sem_arg), 64'(e_a));
      chk(sem_addr === {mregs[4], mregs[5]}, "R6 sem_addr", sem_addr, {mregs[4], mregs[5]});
      chk(sem_seq === mregs[6], "R6 sem_seq", 64'(sem_seq), 64'(mregs[6]));
    end
    chk(unsup_valid === e_uns, "R7 unsup_valid", 64'(unsup_valid), 64'(e_uns));
    if (e_uns) chk(unsup_method === e_m, "R7 unsup_method", 64'(unsup_method), 64'(e_m));
    chk(refcnt === mregs['h14], "R9 refcnt", 64'(refcnt), 64'(mregs['h14]));
    chk(reg_rd_data === mregs[reg_rd_idx], "R3 reg_rd_data", 64'(reg_rd_data), 64'(mregs[reg_rd_idx]));
  endtask

  task automatic cyc(input bit v, input int sc, input int m, input logic [31:0] a,
                     input bit busy, input bit pend, input int ri);
    bit rdy;
    in_valid = v; in_subch = 3'(sc); in_method = 12'(m); in_arg = a;
    sem_busy = busy; sem_acq_pending = pend; reg_rd_idx = 8'(ri);
    rdy = !(busy || pend);
    #1;
    chk(in_ready === rdy, "R8 in_ready", 64'(in_ready), 64'(rdy));
    @(posedge clk);
    e_eng = 0; e_sem = 0; e_uns = 0;
    if (v && rdy) begin
      e_m = 12'(m); e_a = a;
      if (m >= 'h40) begin
        e_eng = 1; e_id = mbind[sc];
      end else begin
        mregs[m] = a;
        case (m)
          'h00: mbind[sc] = a[7:0];
          'h02, 'h04, 'h05, 'h06, 'h14: ;
          'h07: begin e_sem = 1; e_kind = 2'd1; end
          'h1A: begin e_sem = 1; e_kind = 2'd2; end
          'h1B: begin e_sem = 1; e_kind = 2'd3; end
          default: e_uns = 1;
        endcase
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mregs[i] = '0;
    for (int s = 0; s < 8; s++) mbind[s] = '0;
    e_eng = 0; e_sem = 0; e_uns = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    compare_all();
    rst_n = 1;
    @(negedge clk);
    // R1: bindings are 0 after reset
    for (int s = 0; s < 8; s++) cyc(1, s, 'h40 + s, 32'h100 + 32'(s), 0, 0, 0);
    // R4: bind every subchannel, then forward on each (R2)
    for (int s = 0; s < 8; s++) cyc(1, s, 'h0, 32'hABCD_0010 + 32'(s * 3), 0, 0, 0);
    for (int s = 0; s < 8; s++) cyc(1, s, 'hFFF - s, 32'hDEAD_0000 + 32'(s), 0, 0, 0);
    // R4: bind immediately followed by forward on the same subchannel
    cyc(1, 5, 'h0, 32'h77, 0, 0, 0);
    cyc(1, 5, 'h40, 32'h1234, 0, 0, 0);
    // R5 and R3: quiet register updates with read back
    cyc(1, 0, 'h4, 32'h0000_00AA, 0, 0, 4);
    cyc(1, 0, 'h5, 32'h5555_0000, 0, 0, 5);
    cyc(1, 0, 'h6, 32'h0000_0042, 0, 0, 6);
    cyc(1, 1, 'h2, 32'hFEED, 0, 0, 2);
    cyc(1, 2, 'h14, 32'hC0FF_EE01, 0, 0, 'h14);
    // R6: semaphore requests
    cyc(1, 0, 'h7, 32'h2, 0, 0, 7);
    cyc(1, 0, 'h1A, 32'h99, 0, 0, 'h1A);
    cyc(1, 0, 'h1B, 32'h9A, 0, 0, 'h1B);
    // R6: address change right before a trigger
    cyc(1, 0, 'h5, 32'h1111_2222, 0, 0, 5);
    cyc(1, 0, 'h7, 32'h4, 0, 0, 0);
    // R7: unsupported local methods
    cyc(1, 3, 'h8, 32'h1, 0, 0, 8);
    cyc(1, 3, 'h9, 32'h2, 0, 0, 9);
    cyc(1, 3, 'hA, 32'h3, 0, 0, 'hA);
    cyc(1, 3, 'hB, 32'h4, 0, 0, 'hB);
    cyc(1, 3, 'h20, 32'h5, 0, 0, 'h20);
    cyc(1, 3, 'h3F, 32'h6, 0, 0, 'h3F);
    cyc(1, 3, 'h1C, 32'h7, 0, 0, 'h1C);
    // R8: stalled calls are not taken
    cyc(1, 2, 'h14, 32'h0BAD, 1, 0, 'h14);
    cyc(1, 2, 'h0, 32'hEE, 0, 1, 0);
    cyc(1, 2, 'h7, 32'h1, 1, 1, 0);
    cyc(1, 2, 'h41, 32'h5, 1, 0, 0);
    cyc(1, 2, 'h41, 32'h5, 0, 0, 0);
    // idle cycles
    cyc(0, 0, 'h7, 32'h1, 0, 0, 0);
    cyc(0, 0, 'h50, 32'h1, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      int m;
      int sel;
      sel = $urandom_range(0, 9);
      m = (sel < 4) ? $urandom_range('h40, 'hFFF) :
          (sel < 6) ? $urandom_range(0, 7) :
          (sel < 7) ? 'h14 : $urandom_range(0, 'h3F);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), m, $urandom,
          $urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 'h3F));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule